// File: doc/BRIEF.md
# Host-CPU Command Mailbox

This block sits between an 8-bit host bus and a local controller CPU and carries commands, their arguments and their answers between the two. The host writes a command byte and any argument bytes. The CPU picks up the command from a register and pops the arguments from a parameter FIFO. It then pushes its answer bytes into a result FIFO, and the host drains that FIFO through a single read address.

A busy flag tells the host that a command is still in progress. The host write to the command register sets it, and only the CPU clears it. Three interrupt status bits and three enable bits belong to the CPU. The host sees all six in its status byte, and its interrupt line rises only for a status bit whose enable bit is also set. Two self-clearing host control bits are provided. One empties the parameter FIFO. The other starts a short internal initialisation that raises a CPU interrupt. Buffer read data and a data-request flag pass through to the host unchanged.

Top module: `hostcpu_mailbox`

## Requirements
- R1: Host reads decode the 2-bit address: 0 returns the status byte, 1 returns the head of the result FIFO and pops it, 2 returns `buf_rdata` unchanged, 3 returns the FIFO status byte.
- R2: Status bits [2:0] are the CPU interrupt status bits, [5:3] are the CPU enable bits and bit 6 follows `data_req`. `h_irq` is high exactly when some status bit i and enable bit i are both 1.
- R3: Status bit 7 (busy) goes to 1 on a host write to address 0, which also loads `c_cmd`. It returns to 0 only when the CPU writes its control register with bit 6 set.
- R4: The parameter FIFO (host write address 1, CPU pop) is 8 bytes deep and keeps first-in first-out order. A write to a full FIFO is dropped. A pop from an empty FIFO gives 0x00 and changes nothing.
- R5: The result FIFO (CPU push, host read address 1) holds 10 bytes in order. A push to a full FIFO is dropped. A host read of an empty FIFO returns 0x00.
- R6: The FIFO status byte reads bit 0 = parameter FIFO not full, bit 1 = parameter FIFO empty, bit 2 = result FIFO not empty, bit 3 = result FIFO full, and bits 7:4 = 0.
- R7: A host write to address 3 with bit 6 set empties the parameter FIFO at once. The result FIFO is left untouched.
- R8: A host write to address 3 with bit 7 set starts a 4-cycle initialisation. It empties both FIFOs, clears busy and the interrupt status bits, keeps the enables, and drops FIFO writes made during those cycles. It sets `c_irq`, which stays high until `c_irq_ack`.
- R9: The CPU control register reads back as {2'b00, enables[2:0], status[2:0]}. The clear-busy bit 6 always reads as 0.
- R10: A host write to address 2 has no effect on any status or FIFO state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_wr | input | 1 | Host write |
| h_rd | input | 1 | Host read |
| h_addr | input | 2 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (combinational) |
| h_irq | output | 1 | Host interrupt request |
| buf_rdata | input | 8 | Buffer read data passed to host address 2 |
| data_req | input | 1 | Data-request flag shown in status bit 6 |
| c_cmd | output | 8 | Last command byte written by the host |
| c_ctl_we | input | 1 | CPU control register write strobe |
| c_ctl_wdata | input | 7 | CPU control write data: [2:0] status, [5:3] enables, [6] clear busy |
| c_ctl_rdata | output | 8 | CPU control register readback |
| c_par_pop | input | 1 | CPU pop of the parameter FIFO |
| c_par_data | output | 8 | Parameter FIFO head, 0x00 when empty |
| c_par_empty | output | 1 | Parameter FIFO empty |
| c_res_push | input | 1 | CPU push into the result FIFO |
| c_res_wdata | input | 8 | Result byte to push |
| c_res_full | output | 1 | Result FIFO full |
| c_irq | output | 1 | CPU interrupt raised by initialisation |
| c_irq_ack | input | 1 | CPU acknowledge that clears `c_irq` |

## Verification
The assertions assume that the host never raises `h_rd` and `h_wr` in the same cycle and that each access strobe is held for exactly one clock. They also assume the CPU clears busy only through its control register. The stimulus respects this because every host and CPU access comes from a task that raises one strobe on a falling edge and drops it on the next one. The initialisation window is reached by back-to-back accesses issued on consecutive cycles, so the drop of writes made during it can be observed.

// File: rtl/hostcpu_mailbox.sv
module hostcpu_mailbox #(
  parameter int PAR_DEPTH   = 8,
  parameter int RES_DEPTH   = 10,
  parameter int INIT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h_sel,
  input  logic       h_wr,
  input  logic       h_rd,
  input  logic [1:0] h_addr,
  input  logic [7:0] h_wdata,
  output logic [7:0] h_rdata,
  output logic       h_irq,
  input  logic [7:0] buf_rdata,
  input  logic       data_req,
  output logic [7:0] c_cmd,
  input  logic       c_ctl_we,
  input  logic [6:0] c_ctl_wdata,
  output logic [7:0] c_ctl_rdata,
  input  logic       c_par_pop,
  output logic [7:0] c_par_data,
  output logic       c_par_empty,
  input  logic       c_res_push,
  input  logic [7:0] c_res_wdata,
  output logic       c_res_full,
  output logic       c_irq,
  input  logic       c_irq_ack
);
  localparam int PW  = (PAR_DEPTH > 1) ? $clog2(PAR_DEPTH) : 1;
  localparam int RW  = (RES_DEPTH > 1) ? $clog2(RES_DEPTH) : 1;
  localparam int PCW = $clog2(PAR_DEPTH + 1);
  localparam int RCW = $clog2(RES_DEPTH + 1);
  localparam int IW  = $clog2(INIT_CYCLES + 1);
  localparam logic [PCW-1:0] PAR_FULL = PCW'(PAR_DEPTH);
  localparam logic [RCW-1:0] RES_FULL = RCW'(RES_DEPTH);
  localparam logic [PW-1:0]  PAR_LAST = PW'(PAR_DEPTH - 1);
  localparam logic [RW-1:0]  RES_LAST = RW'(RES_DEPTH - 1);

  logic [7:0]     par_mem [PAR_DEPTH];
  logic [7:0]     res_mem [RES_DEPTH];
  logic [PW-1:0]  par_wp, par_rp;
  logic [RW-1:0]  res_wp, res_rp;
  logic [PCW-1:0] par_cnt;
  logic [RCW-1:0] res_cnt;
  logic [IW-1:0]  init_cnt;
  logic [2:0]     ists, ien;
  logic           busy;

  wire h_wen      = h_sel & h_wr;
  wire h_ren      = h_sel & h_rd & ~h_wr;
  wire cmd_we     = h_wen & (h_addr == 2'd0);
  wire par_push   = h_wen & (h_addr == 2'd1);
  wire hctl_we    = h_wen & (h_addr == 2'd3);
  wire init_act   = (init_cnt != '0);
  wire init_start = hctl_we & h_wdata[7];
  wire wipe       = init_start | init_act;
  wire par_clr    = wipe | (hctl_we & h_wdata[6]);

  wire par_empty  = (par_cnt == '0);
  wire par_full   = (par_cnt == PAR_FULL);
  wire res_empty  = (res_cnt == '0);
  wire res_full   = (res_cnt == RES_FULL);

  wire par_do_push = par_push & ~par_full & ~par_clr;
  wire par_do_pop  = c_par_pop & ~par_empty & ~par_clr;
  wire res_do_push = c_res_push & ~res_full & ~wipe;
  wire res_do_pop  = h_ren & (h_addr == 2'd1) & ~res_empty & ~wipe;

  wire [7:0] res_head = res_empty ? 8'h00 : res_mem[res_rp];
  wire [7:0] status   = {busy, data_req, ien, ists};
  wire [7:0] fstat    = {4'b0000, res_full, ~res_empty, par_empty, ~par_full};

  assign c_par_data  = par_empty ? 8'h00 : par_mem[par_rp];
  assign c_par_empty = par_empty;
  assign c_res_full  = res_full;
  assign c_ctl_rdata = {2'b00, ien, ists};
  assign h_irq       = |(ists & ien);

  always_comb begin
    case (h_addr)
      2'd0:    h_rdata = status;
      2'd1:    h_rdata = res_head;
      2'd2:    h_rdata = buf_rdata;
      default: h_rdata = fstat;
    endcase
  end

  // parameter FIFO
  always_ff @(posedge clk) begin
    if (par_do_push) par_mem[par_wp] <= h_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || par_clr) begin
      par_wp  <= '0;
      par_rp  <= '0;
      par_cnt <= '0;
    end else begin
      if (par_do_push) par_wp <= (par_wp == PAR_LAST) ? '0 : par_wp + 1'b1;
      if (par_do_pop)  par_rp <= (par_rp == PAR_LAST) ? '0 : par_rp + 1'b1;
      if (par_do_push && !par_do_pop)      par_cnt <= par_cnt + 1'b1;
      else if (par_do_pop && !par_do_push) par_cnt <= par_cnt - 1'b1;
    end
  end

  // result FIFO
  always_ff @(posedge clk) begin
    if (res_do_push) res_mem[res_wp] <= c_res_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      res_wp  <= '0;
      res_rp  <= '0;
      res_cnt <= '0;
    end else begin
      if (res_do_push) res_wp <= (res_wp == RES_LAST) ? '0 : res_wp + 1'b1;
      if (res_do_pop)  res_rp <= (res_rp == RES_LAST) ? '0 : res_rp + 1'b1;
      if (res_do_push && !res_do_pop)      res_cnt <= res_cnt + 1'b1;
      else if (res_do_pop && !res_do_push) res_cnt <= res_cnt - 1'b1;
    end
  end

  // command, busy, interrupt bits, initialisation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_cmd    <= '0;
      busy     <= 1'b0;
      ists     <= '0;
      ien      <= '0;
      c_irq    <= 1'b0;
      init_cnt <= '0;
    end else begin
      if (cmd_we) c_cmd <= h_wdata;

      if (wipe)                            busy <= 1'b0;
      else if (cmd_we)                     busy <= 1'b1;
      else if (c_ctl_we && c_ctl_wdata[6]) busy <= 1'b0;

      if (c_ctl_we) ien <= c_ctl_wdata[5:3];
      if (wipe)          ists <= '0;
      else if (c_ctl_we) ists <= c_ctl_wdata[2:0];

      if (init_start)     c_irq <= 1'b1;
      else if (c_irq_ack) c_irq <= 1'b0;

      if (init_start && !init_act) init_cnt <= IW'(INIT_CYCLES);
      else if (init_act)           init_cnt <= init_cnt - 1'b1;
    end
  end

  a_r3_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !wipe |=> busy);
  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(c_ctl_we && c_ctl_wdata[6]) && !wipe |=> busy);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    par_cnt <= PAR_FULL);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    res_cnt <= RES_FULL);
  a_r7_clear_param: assert property (@(posedge clk) disable iff (!rst_n)
    hctl_we && h_wdata[6] |=> par_empty);
  a_r8_init_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    init_act |=> par_empty && res_empty && !busy && (ists == 3'b000));
  a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> c_irq);
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    c_irq && !c_irq_ack |=> c_irq);
endmodule

// File: tb/sim_hostcpu_mailbox.sv
module sim_hostcpu_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  // {op[1:0], addr[1:0], data[7:0], expect[7:0]}; op 0 host write, 1 host read+check, 2 cpu ctl write, 3 cpu result push
  localparam logic [19:0] VEC [NVEC] = '{
    {2'd0, 2'd1, 8'h11, 8'h00},
    {2'd0, 2'd1, 8'h22, 8'h00},
    {2'd1, 2'd3, 8'h00, 8'h01},
    {2'd3, 2'd0, 8'hA5, 8'h00},
    {2'd3, 2'd0, 8'h5A, 8'h00},
    {2'd1, 2'd3, 8'h00, 8'h05},
    {2'd1, 2'd1, 8'h00, 8'hA5},
    {2'd1, 2'd1, 8'h00, 8'h5A},
    {2'd1, 2'd1, 8'h00, 8'h00},
    {2'd1, 2'd3, 8'h00, 8'h01},
    {2'd0, 2'd0, 8'h33, 8'h00},
    {2'd1, 2'd0, 8'h00, 8'h80},
    {2'd2, 2'd0, 8'h3F, 8'h00},
    {2'd1, 2'd0, 8'h00, 8'hBF},
    {2'd2, 2'd0, 8'h40, 8'h00},
    {2'd1, 2'd0, 8'h00, 8'h00},
    {2'd0, 2'd3, 8'h40, 8'h00},
    {2'd1, 2'd3, 8'h00, 8'h03}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_sel = 0, h_wr = 0, h_rd = 0;
  logic [1:0] h_addr = 0;
  logic [7:0] h_wdata = 0, h_rdata, buf_rdata = 0, c_cmd, c_ctl_rdata, c_par_data, c_res_wdata = 0;
  logic h_irq, data_req = 0, c_ctl_we = 0, c_par_pop = 0, c_par_empty, c_res_push = 0, c_res_full;
  logic c_irq, c_irq_ack = 0;
  logic [6:0] c_ctl_wdata = 0;
  int checks = 0, failures = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostcpu_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .buf_rdata(buf_rdata),
    .data_req(data_req), .c_cmd(c_cmd), .c_ctl_we(c_ctl_we), .c_ctl_wdata(c_ctl_wdata),
    .c_ctl_rdata(c_ctl_rdata), .c_par_pop(c_par_pop), .c_par_data(c_par_data),
    .c_par_empty(c_par_empty), .c_res_push(c_res_push), .c_res_wdata(c_res_wdata),
    .c_res_full(c_res_full), .c_irq(c_irq), .c_irq_ack(c_irq_ack));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    h_sel = 1; h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_sel = 0; h_wr = 0;
  endtask
  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    h_sel = 1; h_rd = 1; h_addr = a;
    #1 d = h_rdata;
    @(negedge clk); h_sel = 0; h_rd = 0;
  endtask
  task automatic cctl(input logic [7:0] v);
    c_ctl_we = 1; c_ctl_wdata = v[6:0];
    @(negedge clk); c_ctl_we = 0;
  endtask
  task automatic cres(input logic [7:0] v);
    c_res_push = 1; c_res_wdata = v;
    @(negedge clk); c_res_push = 0;
  endtask
  task automatic cpop(output logic [7:0] d);
    c_par_pop = 1;
    #1 d = c_par_data;
    @(negedge clk); c_par_pop = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    hread(2'd0, rv); chk("R2 reset status", rv, 8'h00);
    hread(2'd3, rv); chk("R6 reset fifo status", rv, 8'h03);
    chk("R2 reset h_irq", {7'd0, h_irq}, 8'h00);
    chk("R8 reset c_irq", {7'd0, c_irq}, 8'h00);
    chk("R9 reset ctl", c_ctl_rdata, 8'h00);

    // vector walk: R1 R3 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][19:18])
        2'd0: hwrite(VEC[i][17:16], VEC[i][15:8]);
        2'd1: begin
          hread(VEC[i][17:16], rv);
          chk($sformatf("R1 vector %0d", i), rv, VEC[i][7:0]);
        end
        2'd2: cctl(VEC[i][15:8]);
        default: cres(VEC[i][15:8]);
      endcase
    end

    // R2 interrupt gating
    cctl(8'h09); chk("R2 irq enabled bit0", {7'd0, h_irq}, 8'h01);
    cctl(8'h0A); chk("R2 irq bit1 not enabled", {7'd0, h_irq}, 8'h00);
    cctl(8'h24); chk("R2 irq bit2 enabled", {7'd0, h_irq}, 8'h01);
    cctl(8'h00);

    // R1 / R2 passthroughs
    data_req = 1; buf_rdata = 8'h6C;
    hread(2'd0, rv); chk("R2 data_req in status bit6", rv, 8'h40);
    hread(2'd2, rv); chk("R1 buffer read passthrough", rv, 8'h6C);
    data_req = 0;

    // R10 address 2 write ignored
    hwrite(2'd2, 8'hFF);
    hread(2'd0, rv); chk("R10 status after addr2 write", rv, 8'h00);
    hread(2'd3, rv); chk("R10 fifo status after addr2 write", rv, 8'h03);

    // R3 busy and command
    hwrite(2'd0, 8'h9A);
    chk("R3 command register", c_cmd, 8'h9A);
    cctl(8'h07);
    hread(2'd0, rv); chk("R3 busy kept without clear bit", rv, 8'h87);
    cctl(8'h40);
    hread(2'd0, rv); chk("R3 busy cleared by cpu", rv, 8'h00);
    cctl(8'h7F); chk("R9 clear-busy reads 0", c_ctl_rdata, 8'h3F);
    cctl(8'h00);

    // R4 parameter FIFO fill, overflow, order, empty pop
    for (int i = 0; i < 9; i++) hwrite(2'd1, 8'h10 + 8'(i));
    hread(2'd3, rv); chk("R6 param full status", rv, 8'h00);
    for (int i = 0; i < 8; i++) begin
      cpop(rv); chk($sformatf("R4 param order %0d", i), rv, 8'h10 + 8'(i));
    end
    cpop(rv); chk("R4 empty pop returns 0", rv, 8'h00);
    hwrite(2'd1, 8'h77);
    cpop(rv); chk("R4 pointers intact after empty pop", rv, 8'h77);

    // R5 result FIFO fill, overflow, order, empty read
    for (int i = 0; i < 11; i++) cres(8'h80 + 8'(i));
    chk("R5 c_res_full", {7'd0, c_res_full}, 8'h01);
    hread(2'd3, rv); chk("R6 result full status", rv, 8'h0F);
    for (int i = 0; i < 10; i++) begin
      hread(2'd1, rv); chk($sformatf("R5 result order %0d", i), rv, 8'h80 + 8'(i));
    end
    hread(2'd1, rv); chk("R5 empty read returns 0", rv, 8'h00);

    // R7 clear parameter keeps result
    hwrite(2'd1, 8'h01); cres(8'h02);
    hwrite(2'd3, 8'h40);
    hread(2'd3, rv); chk("R7 param cleared result kept", rv, 8'h07);
    hread(2'd1, rv); chk("R7 result byte survives", rv, 8'h02);

    // R8 initialisation
    cctl(8'h09); hwrite(2'd0, 8'h55); hwrite(2'd1, 8'hAA); cres(8'hBB);
    hwrite(2'd3, 8'h80);
    chk("R8 c_irq raised", {7'd0, c_irq}, 8'h01);
    for (int i = 0; i < 5; i++) hwrite(2'd1, 8'hE1 + 8'(i));
    hread(2'd3, rv); chk("R8 fifos wiped, late push kept", rv, 8'h01);
    cpop(rv); chk("R8 only post-init push remains", rv, 8'hE5);
    hread(2'd0, rv); chk("R8 busy and status cleared, enables kept", rv, 8'h08);
    chk("R8 h_irq low after init", {7'd0, h_irq}, 8'h00);
    chk("R8 c_irq held", {7'd0, c_irq}, 8'h01);
    c_irq_ack = 1; @(negedge clk); c_irq_ack = 0;
    chk("R8 c_irq acknowledged", {7'd0, c_irq}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule